// File: doc/BRIEF.md
# Filtered Incremental Position Decoder

This block turns the two raw feedback lines of one incremental sensor channel into a signed 32-bit position count. A sample enable, derived elsewhere from an encoder sample clock, paces the whole channel. Each line first passes through a short delay chain that advances once per enable, and a majority vote across the chain rejects noise spikes. The voted signals are decoded once per enable, using the format picked by a 4-bit mode input. The formats are step/direction, single-, double- or quadruple-edge quadrature, and separate up and down pulse lines. Each format can count in either sense.

The running count is driven out continuously. It is also copied into two holding registers, one loaded on a phase strobe and one on a servo strobe, so that a processor can read values taken at well-defined instants. In the quadrature formats, a sample in which both lines change at once cannot be decoded. Such a sample leaves the count alone and sets a sticky error flag, which only reset clears.

A slower sample enable widens the spikes the filter removes, but it also lowers the fastest count rate the channel can follow.

Top module: `qdec_channel`

## Requirements
- R1: While reset is held and just after it is released, pos_count, phase_pos and servo_pos are all zero and seq_err is 0.
- R2: Each line is filtered by a three-tap chain with a majority vote, advancing on smp_en. A level that is present for only one enable never reaches the count. A level held for two or more enables does reach it: with smp_en high on every cycle, the count changes at the third rising clock edge after the input change.
- R3: While smp_en is low, the filter taps and the count hold, whatever the inputs do.
- R4: Mode 0 is step/direction. A rising edge of in_a adds 1 when in_b is 0 and subtracts 1 when in_b is 1. A falling edge of in_a, or any change of in_b, leaves the count unchanged.
- R5: Mode 1 is single-edge quadrature. The count changes only on a rising edge of in_a: +1 when in_b is 0 and -1 when in_b is 1. This gives +1 per forward cycle 00,10,11,01,00 (written as in_a,in_b) and -1 per reverse cycle.
- R6: Mode 2 is double-edge quadrature. Each edge of in_a counts: +1 when in_a differs from in_b after the edge, otherwise -1. This gives +2 per forward cycle and -2 per reverse cycle.
- R7: Mode 3 is quadruple-edge quadrature. Each single-line change counts. A change of in_a gives +1 when the new in_a differs from in_b. A change of in_b gives +1 when the new lines are equal. Every other single-line change gives -1. This gives +4 per forward cycle and -4 per reverse cycle.
- R8: Modes 4, 5, 6 and 7 behave as modes 0, 1, 2 and 3 with the sign of every step inverted (mode bit 2 selects the inverted sense).
- R9: Mode 9 counts up and down pulses. A rising edge of in_a adds 1 and a rising edge of in_b subtracts 1; both rising in the same sample leaves the count unchanged. Mode 13 is the same with the signs inverted. These modes never set seq_err.
- R10: In modes 1, 2, 3, 5, 6 and 7, a sample in which both filtered lines change leaves the count unchanged and sets seq_err. seq_err then stays set until reset.
- R11: Mode codes 8, 10, 11, 12, 14 and 15 leave the count unchanged for any input activity.
- R12: On a clock edge with phase_stb high, phase_pos loads the value pos_count held before that edge. servo_stb does the same for servo_pos. A holding register without its strobe keeps its value, even when the count steps in the same cycle or the other strobe fires.
- R13: The count is two's complement and wraps. One step down from 0 gives 32'hFFFFFFFF, and one step up from there gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample enable derived from the encoder sample clock |
| in_a | input | 1 | Raw A (quadrature), step or up-pulse line |
| in_b | input | 1 | Raw B (quadrature), direction or down-pulse line |
| mode | input | 4 | Decode format and count sense |
| phase_stb | input | 1 | Load phase_pos from the count |
| servo_stb | input | 1 | Load servo_pos from the count |
| pos_count | output | 32 | Live signed position count |
| phase_pos | output | 32 | Count held at the last phase strobe |
| servo_pos | output | 32 | Count held at the last servo strobe |
| seq_err | output | 1 | Sticky flag for a quadrature sample where both lines changed |

## Verification
A count step and a strobe can land on the same clock edge. When they do, the holding register must take the count from before the step, and the live count must show the step. The bench sets up this collision by raising in_a in step/direction mode and firing servo_stb exactly on the third edge after the change, where the filter latency puts the step. It then checks that servo_pos holds the old value, that pos_count is one higher and that phase_pos is untouched. Both strobes are then fired together, and both holding registers are checked against the new count.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;

    // Base decode formats (mode with the sense bit cleared)
    localparam logic [3:0] MD_STEPDIR = 4'd0;
    localparam logic [3:0] MD_QUAD1   = 4'd1;
    localparam logic [3:0] MD_QUAD2   = 4'd2;
    localparam logic [3:0] MD_QUAD4   = 4'd3;
    localparam logic [3:0] MD_UPDOWN  = 4'd9;
    localparam logic [3:0] SENSE_MASK = 4'b1011;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    function automatic logic [3:0] base_of(input logic [3:0] m);
        return m & SENSE_MASK;
    endfunction

    function automatic logic is_quad(input logic [3:0] m);
        logic [3:0] b;
        b = base_of(m);
        return (b == MD_QUAD1) || (b == MD_QUAD2) || (b == MD_QUAD4);
    endfunction

    function automatic logic mode_known(input logic [3:0] m);
        logic [3:0] b;
        b = base_of(m);
        return (b == MD_STEPDIR) || is_quad(m) || (b == MD_UPDOWN);
    endfunction

endpackage

// File: rtl/qdec_vote_filter.sv
`timescale 1ns/1ps
module qdec_vote_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(TAPS + 1);
    localparam logic [CW-1:0] HALF = CW'(TAPS / 2);

    typedef struct packed {
        logic [TAPS-1:0] taps;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CW-1:0] ones;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.taps = {st_q.taps[TAPS-2:0], raw};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + CW'(st_q.taps[i]);
        end
    end

    assign filt = (ones > HALF);

    // R3
    taps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(st_q.taps));

endmodule

// File: rtl/qdec_step_logic.sv
`timescale 1ns/1ps
module qdec_step_logic
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic       fa,
    input  logic       fb,
    input  logic [3:0] mode,
    output step_e      step,
    output logic       bad
);
    typedef struct packed {
        logic a;
        logic b;
    } prev_st_t;

    prev_st_t st_d, st_q;
    logic     da, db;
    logic     rev;
    logic     up_ev, dn_ev;
    logic [3:0] base;
    step_e    raw_step;

    always_comb begin
        st_d = st_q;
        if (smp_en) begin
            st_d.a = fa;
            st_d.b = fb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        da       = fa ^ st_q.a;
        db       = fb ^ st_q.b;
        base     = base_of(mode);
        rev      = mode[2];
        up_ev    = 1'b0;
        dn_ev    = 1'b0;
        raw_step = STEP_HOLD;
        case (base)
            MD_STEPDIR: begin
                if (da && fa) raw_step = fb ? STEP_DEC : STEP_INC;
            end
            MD_QUAD1: begin
                if (da && fa && !db) raw_step = fb ? STEP_DEC : STEP_INC;
            end
            MD_QUAD2: begin
                if (da && !db) raw_step = (fa ^ fb) ? STEP_INC : STEP_DEC;
            end
            MD_QUAD4: begin
                if (da && !db) begin
                    raw_step = (fa ^ fb) ? STEP_INC : STEP_DEC;
                end else if (db && !da) begin
                    raw_step = (fa == fb) ? STEP_INC : STEP_DEC;
                end
            end
            MD_UPDOWN: begin
                up_ev = da && fa;
                dn_ev = db && fb;
                if (up_ev && !dn_ev) raw_step = STEP_INC;
                else if (dn_ev && !up_ev) raw_step = STEP_DEC;
            end
            default: raw_step = STEP_HOLD;
        endcase
        if (rev) begin
            if (raw_step == STEP_INC) raw_step = STEP_DEC;
            else if (raw_step == STEP_DEC) raw_step = STEP_INC;
        end
        step = smp_en ? raw_step : STEP_HOLD;
        bad  = smp_en && is_quad(mode) && da && db;
    end

endmodule

// File: rtl/qdec_pos_hold.sv
`timescale 1ns/1ps
module qdec_pos_hold
    import qdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic             bad,
    input  logic             phase_stb,
    input  logic             servo_stb,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] phase_pos,
    output logic [CNT_W-1:0] servo_pos,
    output logic             err
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ph;
        logic [CNT_W-1:0] sv;
        logic             err;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (step)
            STEP_INC: st_d.cnt = st_q.cnt + ONE;
            STEP_DEC: st_d.cnt = st_q.cnt - ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
        if (phase_stb) st_d.ph = st_q.cnt;
        if (servo_stb) st_d.sv = st_q.cnt;
        if (bad)       st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.cnt;
    assign phase_pos = st_q.ph;
    assign servo_pos = st_q.sv;
    assign err       = st_q.err;

    // R13
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + ONE) ||
        (count == $past(count) - ONE));

    // R10
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> $stable(count));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R12
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb |=> (phase_pos == $past(count)));

    // R12
    phase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_stb |=> $stable(phase_pos));

    // R12
    servo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !servo_stb |=> $stable(servo_pos));

endmodule

// File: rtl/qdec_channel.sv
`timescale 1ns/1ps
module qdec_channel
    import qdec_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TAPS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             in_a,
    input  logic             in_b,
    input  logic [3:0]       mode,
    input  logic             phase_stb,
    input  logic             servo_stb,
    output logic [CNT_W-1:0] pos_count,
    output logic [CNT_W-1:0] phase_pos,
    output logic [CNT_W-1:0] servo_pos,
    output logic             seq_err
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    step_e              step;
    logic               bad;

    assign raw_lines = {in_b, in_a};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        qdec_vote_filter #(.TAPS(TAPS)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .smp_en(smp_en),
            .raw   (raw_lines[g]),
            .filt  (clean_lines[g])
        );
    end

    qdec_step_logic u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_en(smp_en),
        .fa    (clean_lines[0]),
        .fb    (clean_lines[1]),
        .mode  (mode),
        .step  (step),
        .bad   (bad)
    );

    qdec_pos_hold #(.CNT_W(CNT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .bad      (bad),
        .phase_stb(phase_stb),
        .servo_stb(servo_stb),
        .count    (pos_count),
        .phase_pos(phase_pos),
        .servo_pos(servo_pos),
        .err      (seq_err)
    );

    // R3
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(pos_count));

    // R11
    unused_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_known(mode) |=> $stable(pos_count));

    // R9
    updown_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_err && !is_quad(mode)) |=> !seq_err);

endmodule

// File: tb/test_qdec_channel.sv
`timescale 1ns/1ps
module test_qdec_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_en;
    logic        in_a, in_b;
    logic [3:0]  mode;
    logic        phase_stb, servo_stb;
    logic [31:0] pos_count, phase_pos, servo_pos;
    logic        seq_err;

    int          n_total = 0;
    int          n_fail  = 0;
    logic [31:0] exp_cnt;
    logic [31:0] exp_ph, exp_sv;

    always #2.5 clk = ~clk;

    qdec_channel i_qdec_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .in_a     (in_a),
        .in_b     (in_b),
        .mode     (mode),
        .phase_stb(phase_stb),
        .servo_stb(servo_stb),
        .pos_count(pos_count),
        .phase_pos(phase_pos),
        .servo_pos(servo_pos),
        .seq_err  (seq_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    task automatic move(input logic a, input logic b);
        @(negedge clk);
        in_a = a;
        in_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic pulse_a(input logic b);
        move(1'b1, b);
        move(1'b0, b);
    endtask

    task automatic quad_fwd();
        move(1'b1, 1'b0);
        move(1'b1, 1'b1);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
    endtask

    task automatic quad_rev();
        move(1'b0, 1'b1);
        move(1'b1, 1'b1);
        move(1'b1, 1'b0);
        move(1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 count", pos_count, 32'd0);
        chk("R1 phase_pos", phase_pos, 32'd0);
        chk("R1 servo_pos", servo_pos, 32'd0);
        chk("R1 seq_err", {31'd0, seq_err}, 32'd0);
    endtask

    task automatic t_wrap();
        set_mode(4'd0);
        move(1'b0, 1'b1);
        pulse_a(1'b1);
        exp_cnt = 32'hFFFF_FFFF;
        chk("R13 wrap below zero", pos_count, exp_cnt);
        move(1'b0, 1'b0);
        pulse_a(1'b0);
        exp_cnt = 32'd0;
        chk("R13 wrap back to zero", pos_count, exp_cnt);
    endtask

    task automatic t_stepdir();
        set_mode(4'd0);
        move(1'b1, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R4 rising step up", pos_count, exp_cnt);
        move(1'b0, 1'b0);
        chk("R4 falling no count", pos_count, exp_cnt);
        move(1'b0, 1'b1);
        chk("R4 dir change no count", pos_count, exp_cnt);
        move(1'b1, 1'b1);
        exp_cnt = exp_cnt - 1;
        chk("R4 rising step down", pos_count, exp_cnt);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
        chk("R4 return idle", pos_count, exp_cnt);
    endtask

    task automatic t_filter();
        set_mode(4'd0);
        @(negedge clk);
        in_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 not yet after two edges", pos_count, exp_cnt);
        @(negedge clk);
        exp_cnt = exp_cnt + 1;
        chk("R2 count at third edge", pos_count, exp_cnt);
        move(1'b0, 1'b0);
        @(negedge clk);
        in_a = 1'b1;
        @(negedge clk);
        in_a = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 one-sample glitch rejected", pos_count, exp_cnt);
        @(negedge clk);
        in_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_a = 1'b0;
        repeat (5) @(negedge clk);
        exp_cnt = exp_cnt + 1;
        chk("R2 two-sample pulse passes", pos_count, exp_cnt);
    endtask

    task automatic t_enable();
        set_mode(4'd0);
        @(negedge clk);
        smp_en = 1'b0;
        in_a = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 held while enable low", pos_count, exp_cnt);
        smp_en = 1'b1;
        repeat (4) @(negedge clk);
        exp_cnt = exp_cnt + 1;
        chk("R3 counts once enabled", pos_count, exp_cnt);
        move(1'b0, 1'b0);
    endtask

    task automatic t_quad();
        set_mode(4'd1);
        quad_fwd();
        exp_cnt = exp_cnt + 1;
        chk("R5 x1 forward", pos_count, exp_cnt);
        quad_rev();
        exp_cnt = exp_cnt - 1;
        chk("R5 x1 reverse", pos_count, exp_cnt);
        set_mode(4'd2);
        quad_fwd();
        exp_cnt = exp_cnt + 2;
        chk("R6 x2 forward", pos_count, exp_cnt);
        quad_rev();
        exp_cnt = exp_cnt - 2;
        chk("R6 x2 reverse", pos_count, exp_cnt);
        set_mode(4'd3);
        move(1'b1, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R7 x4 single step", pos_count, exp_cnt);
        move(1'b1, 1'b1);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
        exp_cnt = exp_cnt + 3;
        chk("R7 x4 forward", pos_count, exp_cnt);
        quad_rev();
        exp_cnt = exp_cnt - 4;
        chk("R7 x4 reverse", pos_count, exp_cnt);
    endtask

    task automatic t_reverse();
        set_mode(4'd7);
        quad_fwd();
        exp_cnt = exp_cnt - 4;
        chk("R8 mode 7 forward", pos_count, exp_cnt);
        set_mode(4'd6);
        quad_fwd();
        exp_cnt = exp_cnt - 2;
        chk("R8 mode 6 forward", pos_count, exp_cnt);
        set_mode(4'd5);
        quad_fwd();
        exp_cnt = exp_cnt - 1;
        chk("R8 mode 5 forward", pos_count, exp_cnt);
        set_mode(4'd4);
        pulse_a(1'b0);
        exp_cnt = exp_cnt - 1;
        chk("R8 mode 4 step", pos_count, exp_cnt);
    endtask

    task automatic t_updown();
        set_mode(4'd9);
        pulse_a(1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R9 up pulse", pos_count, exp_cnt);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
        exp_cnt = exp_cnt - 1;
        chk("R9 down pulse", pos_count, exp_cnt);
        move(1'b1, 1'b1);
        chk("R9 both rise cancel", pos_count, exp_cnt);
        move(1'b0, 1'b0);
        chk("R9 no error flag", {31'd0, seq_err}, 32'd0);
        set_mode(4'd13);
        pulse_a(1'b0);
        exp_cnt = exp_cnt - 1;
        chk("R9 mode 13 up line", pos_count, exp_cnt);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
        exp_cnt = exp_cnt + 1;
        chk("R9 mode 13 down line", pos_count, exp_cnt);
    endtask

    task automatic t_unused(input logic [3:0] m);
        set_mode(m);
        quad_fwd();
        pulse_a(1'b0);
        move(1'b0, 1'b1);
        move(1'b0, 1'b0);
        chk($sformatf("R11 unused mode %0d", m), pos_count, exp_cnt);
    endtask

    task automatic t_latch();
        set_mode(4'd0);
        @(negedge clk);
        phase_stb = 1'b1;
        @(negedge clk);
        phase_stb = 1'b0;
        exp_ph = exp_cnt;
        chk("R12 phase load", phase_pos, exp_ph);
        chk("R12 servo untouched", servo_pos, exp_sv);
        @(negedge clk);
        in_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        servo_stb = 1'b1;
        @(negedge clk);
        servo_stb = 1'b0;
        exp_sv = exp_cnt;
        exp_cnt = exp_cnt + 1;
        chk("R12 collision servo takes old", servo_pos, exp_sv);
        chk("R12 collision count stepped", pos_count, exp_cnt);
        chk("R12 collision phase kept", phase_pos, exp_ph);
        move(1'b0, 1'b0);
        @(negedge clk);
        phase_stb = 1'b1;
        servo_stb = 1'b1;
        @(negedge clk);
        phase_stb = 1'b0;
        servo_stb = 1'b0;
        exp_ph = exp_cnt;
        exp_sv = exp_cnt;
        chk("R12 dual strobe phase", phase_pos, exp_ph);
        chk("R12 dual strobe servo", servo_pos, exp_sv);
    endtask

    task automatic t_illegal();
        set_mode(4'd3);
        chk("R10 flag clear before", {31'd0, seq_err}, 32'd0);
        move(1'b1, 1'b1);
        chk("R10 illegal no count", pos_count, exp_cnt);
        chk("R10 illegal sets flag", {31'd0, seq_err}, 32'd1);
        move(1'b0, 1'b0);
        chk("R10 second illegal no count", pos_count, exp_cnt);
        quad_fwd();
        exp_cnt = exp_cnt + 4;
        chk("R10 legal after illegal", pos_count, exp_cnt);
        chk("R10 flag sticky", {31'd0, seq_err}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        smp_en = 1'b1;
        in_a = 1'b0;
        in_b = 1'b0;
        mode = 4'd0;
        phase_stb = 1'b0;
        servo_stb = 1'b0;
        exp_cnt = 32'd0;
        exp_ph = 32'd0;
        exp_sv = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_stepdir();
        t_filter();
        t_enable();
        t_quad();
        t_reverse();
        t_updown();
        t_unused(4'd8);
        t_unused(4'd11);
        t_unused(4'd12);
        t_unused(4'd15);
        t_latch();
        t_illegal();
        summary();
        $finish;
    end

endmodule